// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block is a bus master that moves Ethernet frames between shared memory and a MAC. Host software builds two rings of descriptors, one for sending and one for receiving. It gives a descriptor to the engine by setting that descriptor's ownership bit. The engine hands the descriptor back by writing a status word in which the ownership bit is clear. Each descriptor occupies four 32-bit words: status at offset 0, control at offset 4, buffer address at offset 8, and a fourth word at offset 12 that the engine never reads. Buffers are word aligned.

A small register port starts and stops each direction, sets the two ring bases, requests a transmit re-scan, issues a soft reset and reports the state of each process. Transmit and receive share one memory port; receive wins when both request in the same cycle. Toward the MAC, transmit data leaves as a byte stream with a valid/ready handshake. Receive data enters as a byte stream that the engine paces with a ready signal.

Top module: `desc_ring_dma`

## Requirements
- R1: Register indices on `reg_addr` are: 0 bus mode, 1 transmit poll, 2 receive ring base, 3 transmit ring base, 4 status, 5 operation mode. After `rst_n` is released, or after a write with bit 0 set to index 0 (soft reset), every readable register reads 0. This covers both state fields, the missed-frame count, the operation mode and both ring bases. Index 0 always reads 0.
- R2: Status word bit 31 is the ownership bit. The transmitter works only on descriptors whose bit 31 is set. When it fetches one whose bit 31 is clear, it enters the suspended state (code 6) and keeps its ring position.
- R3: While transmit is suspended, nothing resumes it except a write with bit 0 set to index 1. That write makes it fetch the same descriptor again.
- R4: The transmitter sends the bytes of a buffer in ascending address order, least significant byte of each word first. The byte count is control bits 10:0. `tx_last` is high on the final byte only when control bit 30 (last segment) is set, and held data stays stable while `tx_ready` is low.
- R5: On transmit completion the engine writes the status word as follows. A normal buffer gets 0x00000000. A buffer of length 0 gets 0x00008000 (bit 15, error summary) and sends no bytes. A descriptor with control bit 27 set (setup frame) gets 0x7FFFFFFF and sends no bytes.
- R6: On both rings the next descriptor is at the current address plus 16. After a descriptor whose control bit 25 is set, the next one is at the ring base.
- R7: A write to a ring base register also moves that ring's current position to the new base.
- R8: Operation mode bit 13 runs transmit and bit 1 runs receive. Clearing a bit stops that process once the current descriptor is finished, or at once when the process is suspended or idle, and the state field then reads 0.
- R9: The engine stores each received byte at buffer plus byte index, using byte enables, so bytes outside the frame are left untouched. The status word written back has bit 31 clear, bit 8 set (last descriptor), and bits 31:16 equal to the number of bytes the frame had on the stream.
- R10: When a frame is longer than control bits 10:0, the engine stores only that many bytes, accepts and discards the rest, and sets status bit 15.
- R11: When the descriptor at the receive position is not owned, the engine accepts and discards the whole frame. It writes nothing, leaves the ring position unchanged, and adds one to the missed count in status bits 15:0.
- R12: The status register reports transmit state in bits 22:20 and receive state in bits 19:17. Transmit codes: 0 stopped, 1 fetching, 3 moving data, 6 suspended, 7 closing. Receive codes: 0 stopped, 1 fetching, 2 waiting for a frame, 3 receiving, 4 discarding, 5 closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | MAC takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte valid |
| rx_last | input | 1 | Final byte of a frame |
| rx_ready | output | 1 | Engine takes the byte |

## Verification
A wrong ring position shows up in the descriptor words written back to memory. Completion lands on the wrong descriptor, or a wrap fails to land on the base, within the few cycles a status write takes. A wrong byte lane or byte count shows on the transmit stream at the very byte it affects, because every handshake is compared with a queue of expected bytes. On receive, a wrong lane or count shows in the buffer words and the written length as soon as the frame closes. A wrong ownership decision shows as a transmitter that sends when it should be suspended, a status field that reads the wrong code, or a missed count that fails to move.

// File: rtl/desc_ring_dma.sv
module desc_ring_dma #(
  parameter int LEN_W  = 11,
  parameter int MISS_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_last,
  output logic        rx_ready
);
  localparam logic [2:0] A_BUS = 3'd0, A_POLL = 3'd1, A_RXB = 3'd2,
                         A_TXB = 3'd3, A_STAT = 3'd4, A_OPM = 3'd5;

  typedef enum logic [2:0] {T_STOP, T_FST, T_FCT, T_FBA, T_RD, T_OUT, T_CLS, T_SUSP} tst_t;
  typedef enum logic [3:0] {R_STOP, R_IDLE, R_FST, R_DROP, R_FCT, R_FBA, R_RECV, R_WR, R_CLS} rst_t;

  logic srst, poll, txb_wr, rxb_wr;
  assign srst   = reg_we && reg_addr == A_BUS && reg_wdata[0];
  assign poll   = reg_we && reg_addr == A_POLL && reg_wdata[0];
  assign txb_wr = reg_we && reg_addr == A_TXB;
  assign rxb_wr = reg_we && reg_addr == A_RXB;

  logic        txen, rxen;
  logic [31:0] txbase, rxbase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen <= 1'b0; rxen <= 1'b0; txbase <= '0; rxbase <= '0;
    end else if (srst) begin
      txen <= 1'b0; rxen <= 1'b0; txbase <= '0; rxbase <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_OPM) begin
        txen <= reg_wdata[13];
        rxen <= reg_wdata[1];
      end
      if (txb_wr) txbase <= reg_wdata;
      if (rxb_wr) rxbase <= reg_wdata;
    end
  end

  // shared memory port, receive has priority
  logic        busy, own_rx, sel_rx, tx_ack, rx_ack;
  logic        tx_mreq, tx_mwe, rx_mreq, rx_mwe;
  logic [31:0] tx_maddr, tx_mwdata, rx_maddr, rx_mwdata;
  logic [3:0]  rx_mbe;

  assign sel_rx    = busy ? own_rx : rx_mreq;
  assign mem_req   = busy | rx_mreq | tx_mreq;
  assign mem_addr  = sel_rx ? rx_maddr  : tx_maddr;
  assign mem_we    = sel_rx ? rx_mwe    : tx_mwe;
  assign mem_wdata = sel_rx ? rx_mwdata : tx_mwdata;
  assign mem_be    = sel_rx ? rx_mbe    : 4'hF;
  assign tx_ack    = busy && mem_ack && !own_rx;
  assign rx_ack    = busy && mem_ack && own_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; own_rx <= 1'b0;
    end else if (srst) begin
      busy <= 1'b0; own_rx <= 1'b0;
    end else if (!busy && mem_req) begin
      busy <= 1'b1; own_rx <= sel_rx;
    end else if (busy && mem_ack) begin
      busy <= 1'b0;
    end
  end

  // transmit process
  tst_t             ts;
  logic [31:0]      txptr, tbuf, tword, twb;
  logic [LEN_W-1:0] tlen, trem;
  logic             t_ls, t_set, t_eor;
  logic [1:0]       tlane;

  always_comb begin
    tx_mreq = 1'b1; tx_mwe = 1'b0; tx_maddr = txptr;
    case (ts)
      T_FCT:   tx_maddr = txptr + 32'd4;
      T_FBA:   tx_maddr = txptr + 32'd8;
      T_RD:    tx_maddr = tbuf;
      T_CLS:   tx_mwe = 1'b1;
      T_FST:   ;
      default: tx_mreq = 1'b0;
    endcase
  end
  assign tx_mwdata = twb;
  assign tx_valid  = ts == T_OUT;
  assign tx_data   = tword[8*tlane +: 8];
  assign tx_last   = t_ls && trem == LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts <= T_STOP; txptr <= '0; tbuf <= '0; tword <= '0; twb <= '0;
      tlen <= '0; trem <= '0; t_ls <= 1'b0; t_set <= 1'b0; t_eor <= 1'b0; tlane <= '0;
    end else if (srst) begin
      ts <= T_STOP; txptr <= '0;
    end else begin
      if (txb_wr) txptr <= reg_wdata;
      case (ts)
        T_STOP: if (txen) ts <= T_FST;
        T_FST:  if (tx_ack) ts <= mem_rdata[31] ? T_FCT : T_SUSP;
        T_SUSP: if (!txen) ts <= T_STOP; else if (poll) ts <= T_FST;
        T_FCT: if (tx_ack) begin
          t_ls <= mem_rdata[30]; t_set <= mem_rdata[27]; t_eor <= mem_rdata[25];
          tlen <= mem_rdata[LEN_W-1:0];
          ts <= T_FBA;
        end
        T_FBA: if (tx_ack) begin
          tbuf <= mem_rdata; trem <= tlen; tlane <= '0;
          if (t_set) begin twb <= 32'h7FFF_FFFF; ts <= T_CLS; end
          else if (tlen == '0) begin twb <= 32'h0000_8000; ts <= T_CLS; end
          else begin twb <= '0; ts <= T_RD; end
        end
        T_RD: if (tx_ack) begin tword <= mem_rdata; ts <= T_OUT; end
        T_OUT: if (tx_ready) begin
          trem <= trem - LEN_W'(1);
          tlane <= tlane + 2'd1;
          if (trem == LEN_W'(1)) ts <= T_CLS;
          else if (tlane == 2'd3) begin tbuf <= tbuf + 32'd4; ts <= T_RD; end
        end
        T_CLS: if (tx_ack) begin
          txptr <= t_eor ? txbase : txptr + 32'd16;
          ts <= txen ? T_FST : T_STOP;
        end
        default: ts <= T_STOP;
      endcase
    end
  end

  // receive process
  rst_t              rs;
  logic [31:0]       rxptr, rbuf, racc, rwaddr;
  logic [LEN_W-1:0]  rlen;
  logic              r_eor, rlastseen;
  logic [15:0]       rcnt;
  logic [3:0]        rbe;
  logic [MISS_W-1:0] miss;
  logic              keep, flush;
  logic [1:0]        lane;

  assign lane  = rcnt[1:0];
  assign keep  = rcnt < 16'(rlen);
  assign flush = keep && (lane == 2'd3 || rx_last || rcnt == 16'(rlen) - 16'd1);
  assign rx_ready = rs == R_DROP || rs == R_RECV;

  always_comb begin
    rx_mreq = 1'b1; rx_mwe = 1'b0; rx_maddr = rxptr; rx_mbe = 4'hF;
    rx_mwdata = {rcnt, rcnt > 16'(rlen), 6'b0, 1'b1, 8'b0};
    case (rs)
      R_FCT:   rx_maddr = rxptr + 32'd4;
      R_FBA:   rx_maddr = rxptr + 32'd8;
      R_WR:    begin rx_mwe = 1'b1; rx_maddr = rwaddr; rx_mwdata = racc; rx_mbe = rbe; end
      R_CLS:   rx_mwe = 1'b1;
      R_FST:   ;
      default: rx_mreq = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= R_STOP; rxptr <= '0; rbuf <= '0; racc <= '0; rwaddr <= '0; rlen <= '0;
      r_eor <= 1'b0; rlastseen <= 1'b0; rcnt <= '0; rbe <= '0; miss <= '0;
    end else if (srst) begin
      rs <= R_STOP; rxptr <= '0; miss <= '0;
    end else begin
      if (rxb_wr) rxptr <= reg_wdata;
      case (rs)
        R_STOP: if (rxen) rs <= R_IDLE;
        R_IDLE: if (!rxen) rs <= R_STOP; else if (rx_valid) rs <= R_FST;
        R_FST:  if (rx_ack) rs <= mem_rdata[31] ? R_FCT : R_DROP;
        R_DROP: if (rx_valid && rx_last) begin miss <= miss + 1'b1; rs <= R_IDLE; end
        R_FCT: if (rx_ack) begin
          r_eor <= mem_rdata[25]; rlen <= mem_rdata[LEN_W-1:0]; rs <= R_FBA;
        end
        R_FBA: if (rx_ack) begin
          rbuf <= mem_rdata; rcnt <= '0; racc <= '0; rbe <= '0; rs <= R_RECV;
        end
        R_RECV: if (rx_valid) begin
          rcnt <= rcnt + 16'd1;
          rlastseen <= rx_last;
          if (keep) begin
            racc[8*lane +: 8] <= rx_data;
            rbe[lane] <= 1'b1;
            rwaddr <= rbuf + {16'b0, rcnt[15:2], 2'b00};
          end
          if (flush) rs <= R_WR;
          else if (rx_last) rs <= R_CLS;
        end
        R_WR: if (rx_ack) begin
          racc <= '0; rbe <= '0;
          rs <= rlastseen ? R_CLS : R_RECV;
        end
        R_CLS: if (rx_ack) begin
          rxptr <= r_eor ? rxbase : rxptr + 32'd16;
          rs <= rxen ? R_IDLE : R_STOP;
        end
        default: rs <= R_STOP;
      endcase
    end
  end

  // register read
  logic [2:0] tcode, rcode;
  always_comb begin
    case (ts)
      T_FST, T_FCT, T_FBA: tcode = 3'd1;
      T_RD, T_OUT:         tcode = 3'd3;
      T_CLS:               tcode = 3'd7;
      T_SUSP:              tcode = 3'd6;
      default:             tcode = 3'd0;
    endcase
    case (rs)
      R_FST, R_FCT, R_FBA: rcode = 3'd1;
      R_IDLE:              rcode = 3'd2;
      R_RECV, R_WR:        rcode = 3'd3;
      R_DROP:              rcode = 3'd4;
      R_CLS:               rcode = 3'd5;
      default:             rcode = 3'd0;
    endcase
    case (reg_addr)
      A_RXB:   reg_rdata = rxbase;
      A_TXB:   reg_rdata = txbase;
      A_STAT:  reg_rdata = {9'b0, tcode, rcode, 17'b0} | 32'(miss);
      A_OPM:   reg_rdata = {18'b0, txen, 11'b0, rxen, 1'b0};
      default: reg_rdata = '0;
    endcase
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || srst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || srst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4
  AST_SUSP_KEEP: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ts == T_SUSP && txen && !poll && !txb_wr |=> ts == T_SUSP && $stable(txptr)); // R2
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && mem_we |-> !mem_wdata[31] && mem_addr == txptr); // R5
  AST_RX_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && rs == R_CLS |-> mem_wdata[8] && !mem_wdata[31] && mem_be == 4'hF); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> tcode == 3'd0 && rcode == 3'd0 && !txen && !rxen && miss == '0); // R1
endmodule

// File: tb/test_desc_ring_dma.sv
module test_desc_ring_dma;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, reg_we, mem_req, mem_we, mem_ack;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_last, tx_ready, rx_valid, rx_last, rx_ready;

  desc_ring_dma i_desc_ring_dma (.*);

  localparam logic [31:0] OWN = 32'h8000_0000, LS = 32'h4000_0000, FS = 32'h2000_0000,
                          SETF = 32'h0800_0000, EOR = 32'h0200_0000;

  int n_cmp = 0, n_bad = 0, cyc = 0, rdy_mode = 0;
  bit done = 0;
  logic [31:0] mem [0:1023];
  logic        ack_r;
  logic [31:0] rd_r;
  logic [8:0]  exp_q[$];

  assign mem_ack   = ack_r;
  assign mem_rdata = rd_r;

  always @(posedge clk) begin
    if (!rst_n) ack_r <= 1'b0;
    else if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      rd_r  <= mem[mem_addr[11:2]];
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
    end else ack_r <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 tx_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 1);
  end

  // per-cycle transmit stream comparison against the expected queue (R4)
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk("R4 unexpected byte", {23'b0, tx_last, tx_data}, 32'h1FF);
      else chk("R4 tx byte", {23'b0, tx_last, tx_data}, {23'b0, exp_q.pop_front()});
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic setd(input int a, input logic [31:0] st, input logic [31:0] ct, input logic [31:0] bp);
    mem[a/4] = st; mem[a/4+1] = ct; mem[a/4+2] = bp; mem[a/4+3] = 32'h0;
  endtask

  task automatic load_tx(input int a, input int n, input logic [7:0] s, input bit last);
    for (int i = 0; i < n; i++) begin
      mem[(a+i)/4][8*((a+i)%4) +: 8] = s + 8'(i);
      exp_q.push_back({last && i == n-1, s + 8'(i)});
    end
  endtask

  task automatic wait_tx(input logic [2:0] code);
    logic [31:0] v;
    for (int k = 0; k < 600; k++) begin
      rd_reg(3'd4, v);
      if (v[22:20] == code) break;
    end
  endtask

  task automatic wait_q();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] s);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = s + 8'(i); rx_last = (i == n-1);
      do @(negedge clk); while (!rx_ready);
      @(posedge clk); #1;
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (20) @(posedge clk);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_last = 0; rx_data = 0; tx_ready = 1;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_A5A5;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    rd_reg(3'd4, v); chk("R1 status after reset", v, 32'h0);
    rd_reg(3'd5, v); chk("R1 opmode after reset", v, 32'h0);

    wr_reg(3'd3, 32'h100);
    wr_reg(3'd2, 32'h200);
    setd(32'h100, OWN, FS | LS | 32'd7, 32'h400);
    load_tx(32'h400, 7, 8'h10, 1);
    setd(32'h110, OWN, SETF | 32'd192, 32'h480);
    setd(32'h120, OWN, EOR, 32'h4C0);
    rdy_mode = 1;
    wr_reg(3'd5, 32'h2000);
    wait_tx(3'd6);
    rd_reg(3'd4, v); chk("R2 R12 suspended on unowned", {29'b0, v[22:20]}, 32'd6);
    chk("R5 normal writeback", mem[32'h40], 32'h0);
    chk("R5 setup writeback", mem[32'h44], 32'h7FFF_FFFF);
    chk("R5 zero length writeback", mem[32'h48], 32'h0000_8000);
    chk("R4 all bytes sent", 32'(exp_q.size()), 32'd0);

    // R3: suspended transmitter waits for poll, then R6 wrap to base
    setd(32'h100, OWN, FS | 32'd10, 32'h500);
    load_tx(32'h500, 10, 8'h30, 0);
    repeat (40) @(posedge clk);
    chk("R3 no progress without poll", mem[32'h40], OWN);
    chk("R3 no bytes without poll", 32'(exp_q.size()), 32'd10);
    wr_reg(3'd1, 32'h1);
    wait_q();
    wait_tx(3'd6);
    chk("R6 R3 wrapped descriptor completed", mem[32'h40], 32'h0);

    // R7: base write relocates the ring position
    setd(32'h180, OWN, EOR | LS | 32'd3, 32'h540);
    load_tx(32'h540, 3, 8'h50, 1);
    wr_reg(3'd3, 32'h180);
    wr_reg(3'd1, 32'h1);
    wait_q();
    wait_tx(3'd6);
    chk("R7 relocated descriptor completed", mem[32'h60], 32'h0);
    rd_reg(3'd3, v); chk("R7 base readback", v, 32'h180);

    wr_reg(3'd5, 32'h0);
    repeat (2) @(posedge clk);
    rd_reg(3'd4, v); chk("R8 tx stopped", {29'b0, v[22:20]}, 32'd0);

    // receive ring
    setd(32'h200, OWN, 32'd64, 32'h600);
    setd(32'h210, OWN, EOR | 32'd6, 32'h700);
    wr_reg(3'd5, 32'h2);
    repeat (3) @(posedge clk);
    rd_reg(3'd4, v); chk("R12 rx waiting", {29'b0, v[19:17]}, 32'd2);
    rd_reg(3'd5, v); chk("R8 opmode readback", v, 32'h2);
    send_frame(10, 8'h60);
    chk("R9 rx status", mem[32'h80], 32'h000A_0100);
    chk("R9 rx word0", mem[32'h180], 32'h6362_6160);
    chk("R9 rx word1", mem[32'h181], 32'h6766_6564);
    chk("R9 rx partial word", mem[32'h182], 32'hA5A5_6968);
    send_frame(9, 8'h70);
    chk("R10 truncated status", mem[32'h84], 32'h0009_8100);
    chk("R10 kept word", mem[32'h1C0], 32'h7372_7170);
    chk("R10 cut word", mem[32'h1C1], 32'hA5A5_7574);
    chk("R10 beyond buffer", mem[32'h1C2], 32'hA5A5_A5A5);

    // R6 receive wrap lands on the first descriptor, which is not owned: R11
    send_frame(4, 8'h80);
    rd_reg(3'd4, v); chk("R11 missed count", {16'b0, v[15:0]}, 32'd1);
    chk("R11 status untouched", mem[32'h80], 32'h000A_0100);
    chk("R11 buffer untouched", mem[32'h180], 32'h6362_6160);
    setd(32'h200, OWN, 32'd64, 32'h600);
    send_frame(4, 8'h90);
    chk("R11 R6 same position reused", mem[32'h80], 32'h0004_0100);
    chk("R9 rx short frame", mem[32'h180], 32'h9392_9190);

    wr_reg(3'd5, 32'h0);
    repeat (2) @(posedge clk);
    rd_reg(3'd4, v); chk("R8 rx stopped", {29'b0, v[19:17]}, 32'd0);

    wr_reg(3'd5, 32'h2002);
    repeat (10) @(posedge clk);
    wr_reg(3'd0, 32'h1);
    repeat (2) @(posedge clk);
    rd_reg(3'd4, v); chk("R1 status after soft reset", v, 32'h0);
    rd_reg(3'd5, v); chk("R1 opmode after soft reset", v, 32'h0);
    rd_reg(3'd3, v); chk("R1 tx base after soft reset", v, 32'h0);
    rd_reg(3'd0, v); chk("R1 bus mode reads zero", v, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule